// File: doc/BRIEF.md
# CAM Command Decoder with Persistent Port Steering

This block sits on the command path of a small content-addressable memory. Each command write carries a 16-bit instruction word. The block decodes that word into selections that stay in force: the data-read source, and the data-write destination together with its mask and validity settings. It also decodes one-cycle strobes for move and validity-control operations, with their argument fields. The array, the compare engine and the move datapath sit outside. They see only the selects, the argument fields and the strobes.

A one-shot override instruction redirects only the next command cycle to a chosen register. In read mode, that cycle's command read returns the register on the low half of the bus and the upper half of Status on the high half. In write mode, that cycle's command write goes to the register instead of the decoder. Command reads otherwise return the full 32-bit Status word, and command writes otherwise go to the decoder. The source-view register carries a fixed device identifier above its select code. Four register codes cannot be written.

Top module: `camcmd_top`

## Requirements
- R1: After reset, srcSel, dstSel, dstMask and dstValid are all 0 (code 0 means the Comparand register). No override is armed, and movStb, vbcStb and regWrEn are low.
- R2: A command write of the source-select pattern sets srcSel to bits 2:0. The pattern is bits 15:12 = 0, bits 10:8 = 000 and bits 7:3 = 0. The new value shows from the clock edge that takes the write. It holds until the next source-select instruction or a reset.
- R3: A command write with bits 15:12 = 0 and bits 10:8 = 001 sets dstMask, dstSel and dstValid together. dstMask takes bits 7:6, dstSel takes bits 5:3 and dstValid takes bits 2:0. The values hold until the next such write or a reset. Source select and destination select never change each other.
- R4: A command write with bits 15:12 = 0 and bits 10:8 = 011 makes movStb high for exactly the cycle after the edge. In that cycle argFlag = bit 11, argMask = bits 7:6, argDst = bits 5:3 and argLow = bits 2:0. The persistent selects do not change.
- R5: A command write with bits 15:12 = 0, bits 10:8 = 100 and bits 7:6 = 0 makes vbcStb high for the cycle after the edge. In that cycle argFlag = bit 11, argDst = bits 5:3, argLow = bits 2:0 and argMask = 0.
- R6: Any other command word is a no-operation. This covers nonzero bits 15:12, function codes 101, 110 and 111, and nonzero reserved bits. Such a word changes no select and raises no strobe.
- R7: A command write with bits 15:12 = 0, bits 10:8 = 010, bits 7:6 = 0 and bits 2:0 = 0 arms an override. Bits 5:3 name the register and bit 11 = 1 selects write mode. The next command cycle, read or write, consumes the override.
- R8: During the one read that consumes a read-mode override, regRdEn is high and regRdSel is the register code. dqOut[15:0] carries the register data and dqOut[31:16] = statusIn[31:16]. A command write in that cycle is decoded as an instruction.
- R9: A command write that consumes a write-mode override is not decoded. In the cycle after it, regWrEn is high for one cycle, regWrSel holds the register code and regWrData holds the written word. A command read in that consuming cycle returns Status.
- R10: Register codes 3 (next-free), 4 (Status), 5 (source view) and 6 (destination view) cannot be written. A write-mode override to any of them consumes the override and raises no regWrEn.
- R11: Override read data depends on the code. Code 4 reads statusIn[15:0]. Code 5 reads {DEV_ID[11:0], 1'b0, srcSel}. Code 6 reads {8'h00, dstMask, dstSel, dstValid}. Every other code reads regRdData.
- R12: Whenever no override is armed, dqOut equals statusIn on all 32 bits. After the override cycle, reads return Status again and writes go to the decoder again.
- R13: When cmdRd and cmdWr are both high in a read-mode override cycle, the read is served from the state before the edge and the write is decoded. The override is consumed only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe |
| cmdRd | input | 1 | Command read strobe |
| wrData | input | 16 | Command write data (instruction or register value) |
| statusIn | input | 32 | Current Status word from the array |
| regRdData | input | 16 | Data of the register named by regRdSel |
| dqOut | output | 32 | Command read data |
| srcSel | output | 3 | Persistent data-read source |
| dstSel | output | 3 | Persistent data-write destination |
| dstMask | output | 2 | Mask select for the destination |
| dstValid | output | 3 | Validity setting for the destination |
| movStb | output | 1 | Move operation strobe |
| vbcStb | output | 1 | Validity-control strobe |
| argFlag | output | 1 | Address-field flag of the strobed operation |
| argMask | output | 2 | Mask select of the strobed operation |
| argDst | output | 3 | Target field of the strobed operation |
| argLow | output | 3 | Source or validity field of the strobed operation |
| regRdEn | output | 1 | Override register read in progress |
| regRdSel | output | 3 | Register code for the override read |
| regWrEn | output | 1 | Override register write pulse |
| regWrSel | output | 3 | Register code for the override write |
| regWrData | output | 16 | Data for the override write |

## Verification
The cycle that consumes an override can also carry a second command strobe. A read-mode override can see a command write in the same cycle, which must still be decoded. A write-mode override can see a command read in the same cycle, which must return plain Status. The bench drives both strobes together just after a read-mode override. It checks that dqOut carries the register view during that cycle and that the new source select appears after the edge. It then makes a read to confirm that Status is back and that the override was not consumed twice.

// File: rtl/camcmd_pkg.sv
package camcmd_pkg;

  localparam logic [2:0] FN_SRC = 3'b000;
  localparam logic [2:0] FN_DST = 3'b001;
  localparam logic [2:0] FN_OVR = 3'b010;
  localparam logic [2:0] FN_MOV = 3'b011;
  localparam logic [2:0] FN_VBC = 3'b100;

  localparam logic [2:0] RG_NEXTFREE = 3'd3;
  localparam logic [2:0] RG_STATUS   = 3'd4;
  localparam logic [2:0] RG_SRCVIEW  = 3'd5;
  localparam logic [2:0] RG_DSTVIEW  = 3'd6;

  typedef struct packed {
    logic       armed;
    logic       wrMode;
    logic [2:0] regCode;
    logic       rdSlot;
    logic       wrSlot;
    logic [2:0] srcView;
    logic [7:0] dstView;
  } ovrLink_t;

  function automatic logic isReadOnly(input logic [2:0] code);
    return (code == RG_NEXTFREE) || (code == RG_STATUS) ||
           (code == RG_SRCVIEW)  || (code == RG_DSTVIEW);
  endfunction

endpackage

// File: rtl/camcmd_ctrl.sv
module camcmd_ctrl
  import camcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       cmdRd,
  input  logic [15:0] opWord,
  output ovrLink_t   link,
  output logic [2:0] srcSel,
  output logic [2:0] dstSel,
  output logic [1:0] dstMask,
  output logic [2:0] dstValid,
  output logic       movStb,
  output logic       vbcStb,
  output logic       argFlag,
  output logic [1:0] argMask,
  output logic [2:0] argDst,
  output logic [2:0] argLow
);

  logic [2:0] srcQ, dstQ, validQ, regCodeQ;
  logic [1:0] maskQ;
  logic       armedQ, wrModeQ;
  logic       movQ, vbcQ, flagQ;
  logic [1:0] aMaskQ;
  logic [2:0] aDstQ, aLowQ;

  logic       decodeEn, upperZero, flagBit, consume;
  logic [2:0] func;
  logic       isSps, isSpd, isMov, isOvr, isVbc;

  always_comb begin
    decodeEn  = cmdWr && !(armedQ && wrModeQ);
    upperZero = (opWord[15:12] == 4'd0);
    flagBit   = opWord[11];
    func      = opWord[10:8];
    isSps = decodeEn && upperZero && (func == FN_SRC) && (opWord[7:3] == 5'd0);
    isSpd = decodeEn && upperZero && (func == FN_DST);
    isMov = decodeEn && upperZero && (func == FN_MOV);
    isOvr = decodeEn && upperZero && (func == FN_OVR) &&
            (opWord[7:6] == 2'd0) && (opWord[2:0] == 3'd0);
    isVbc = decodeEn && upperZero && (func == FN_VBC) && (opWord[7:6] == 2'd0);
    consume = armedQ && (cmdWr || cmdRd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= '0;
      dstQ     <= '0;
      maskQ    <= '0;
      validQ   <= '0;
      armedQ   <= 1'b0;
      wrModeQ  <= 1'b0;
      regCodeQ <= '0;
      movQ     <= 1'b0;
      vbcQ     <= 1'b0;
      flagQ    <= 1'b0;
      aMaskQ   <= '0;
      aDstQ    <= '0;
      aLowQ    <= '0;
    end else begin
      if (isSps) srcQ <= opWord[2:0];
      if (isSpd) begin
        maskQ  <= opWord[7:6];
        dstQ   <= opWord[5:3];
        validQ <= opWord[2:0];
      end
      movQ <= isMov;
      vbcQ <= isVbc;
      if (isMov || isVbc) begin
        flagQ  <= flagBit;
        aMaskQ <= isMov ? opWord[7:6] : 2'b00;
        aDstQ  <= opWord[5:3];
        aLowQ  <= opWord[2:0];
      end
      if (isOvr) begin
        armedQ   <= 1'b1;
        wrModeQ  <= flagBit;
        regCodeQ <= opWord[5:3];
      end else if (consume) begin
        armedQ <= 1'b0;
      end
    end
  end

  always_comb begin
    link.armed   = armedQ;
    link.wrMode  = wrModeQ;
    link.regCode = regCodeQ;
    link.rdSlot  = cmdRd && armedQ && !wrModeQ;
    link.wrSlot  = cmdWr && armedQ && wrModeQ;
    link.srcView = srcQ;
    link.dstView = {maskQ, dstQ, validQ};
  end

  assign srcSel   = srcQ;
  assign dstSel   = dstQ;
  assign dstMask  = maskQ;
  assign dstValid = validQ;
  assign movStb   = movQ;
  assign vbcStb   = vbcQ;
  assign argFlag  = flagQ;
  assign argMask  = aMaskQ;
  assign argDst   = aDstQ;
  assign argLow   = aLowQ;

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> $stable(srcSel)); // R2
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> $stable({dstMask, dstSel, dstValid})); // R3
  AST_OVR_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    armedQ && cmdRd && !cmdWr |=> !armedQ); // R7
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && (opWord[15:12] != 4'd0) |=> $stable(srcSel) && !movStb && !vbcStb); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(movStb && vbcStb)); // R4

endmodule

// File: rtl/camcmd_dp.sv
module camcmd_dp
  import camcmd_pkg::*;
#(
  parameter logic [11:0] DEV_ID = 12'hA5C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] wrData,
  input  logic [31:0] statusIn,
  input  logic [15:0] regRdData,
  input  ovrLink_t    link,
  output logic [31:0] dqOut,
  output logic        regRdEn,
  output logic [2:0]  regRdSel,
  output logic        regWrEn,
  output logic [2:0]  regWrSel,
  output logic [15:0] regWrData
);

  localparam int HALF = 16;

  logic [HALF-1:0] viewWord;
  logic            wrEnQ;
  logic [2:0]      wrSelQ;
  logic [HALF-1:0] wrDataQ;

  always_comb begin
    case (link.regCode)
      RG_STATUS:  viewWord = statusIn[HALF-1:0];
      RG_SRCVIEW: viewWord = {DEV_ID, 1'b0, link.srcView};
      RG_DSTVIEW: viewWord = {8'h00, link.dstView};
      default:    viewWord = regRdData;
    endcase
    if (link.armed && !link.wrMode)
      dqOut = {statusIn[31:HALF], viewWord};
    else
      dqOut = statusIn;
  end

  assign regRdEn  = link.rdSlot;
  assign regRdSel = link.regCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrSelQ  <= '0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= link.wrSlot && !isReadOnly(link.regCode);
      if (link.wrSlot) begin
        wrSelQ  <= link.regCode;
        wrDataQ <= wrData;
      end
    end
  end

  assign regWrEn   = wrEnQ;
  assign regWrSel  = wrSelQ;
  assign regWrData = wrDataQ;

  AST_STATUS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !link.armed |-> dqOut == statusIn); // R12
  AST_UPPER_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |-> dqOut[31:16] == statusIn[31:16]); // R8
  AST_RO_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !isReadOnly(regWrSel)); // R10
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regWrEn)); // R9
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R9

endmodule

// File: rtl/camcmd_top.sv
module camcmd_top
  import camcmd_pkg::*;
#(
  parameter logic [11:0] DEV_ID = 12'hA5C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic        cmdRd,
  input  logic [15:0] wrData,
  input  logic [31:0] statusIn,
  input  logic [15:0] regRdData,
  output logic [31:0] dqOut,
  output logic [2:0]  srcSel,
  output logic [2:0]  dstSel,
  output logic [1:0]  dstMask,
  output logic [2:0]  dstValid,
  output logic        movStb,
  output logic        vbcStb,
  output logic        argFlag,
  output logic [1:0]  argMask,
  output logic [2:0]  argDst,
  output logic [2:0]  argLow,
  output logic        regRdEn,
  output logic [2:0]  regRdSel,
  output logic        regWrEn,
  output logic [2:0]  regWrSel,
  output logic [15:0] regWrData
);

  ovrLink_t link;

  camcmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdRd(cmdRd), .opWord(wrData),
    .link(link), .srcSel(srcSel), .dstSel(dstSel), .dstMask(dstMask),
    .dstValid(dstValid), .movStb(movStb), .vbcStb(vbcStb), .argFlag(argFlag),
    .argMask(argMask), .argDst(argDst), .argLow(argLow)
  );

  camcmd_dp #(.DEV_ID(DEV_ID)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .statusIn(statusIn),
    .regRdData(regRdData), .link(link), .dqOut(dqOut), .regRdEn(regRdEn),
    .regRdSel(regRdSel), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData)
  );

endmodule

// File: tb/camcmd_top_tb_top.sv
`timescale 1ns/1ps
module camcmd_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic        cmdRd = 1'b0;
  logic [15:0] wrData = '0;
  logic [31:0] statusIn = 32'hDEAD_BEEF;
  logic [15:0] regRdData = 16'h1234;
  logic [31:0] dqOut;
  logic [2:0]  srcSel, dstSel, dstValid, argDst, argLow, regRdSel, regWrSel;
  logic [1:0]  dstMask, argMask;
  logic        movStb, vbcStb, argFlag, regRdEn, regWrEn;
  logic [15:0] regWrData;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  camcmd_top dut_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdRd(cmdRd), .wrData(wrData),
    .statusIn(statusIn), .regRdData(regRdData), .dqOut(dqOut),
    .srcSel(srcSel), .dstSel(dstSel), .dstMask(dstMask), .dstValid(dstValid),
    .movStb(movStb), .vbcStb(vbcStb), .argFlag(argFlag), .argMask(argMask),
    .argDst(argDst), .argLow(argLow), .regRdEn(regRdEn), .regRdSel(regRdSel),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData)
  );

  // {opcode[15:0], expected src[2:0], expected {mask,dst,valid}[7:0], expected {mov,vbc}}
  localparam logic [28:0] VEC [12] = '{
    {16'h0003, 3'd3, 8'h00, 2'b00},  // R2 select source 3
    {16'h01B5, 3'd3, 8'hB5, 2'b00},  // R3 select destination
    {16'h0807, 3'd7, 8'hB5, 2'b00},  // R2 flag set, source 7
    {16'h1002, 3'd7, 8'hB5, 2'b00},  // R6 upper nibble nonzero
    {16'h0502, 3'd7, 8'hB5, 2'b00},  // R6 function 101
    {16'h000A, 3'd7, 8'hB5, 2'b00},  // R6 reserved bit set
    {16'h0300, 3'd7, 8'hB5, 2'b10},  // R4 move leaves selects
    {16'h0400, 3'd7, 8'hB5, 2'b01},  // R5 validity control
    {16'h0142, 3'd7, 8'h42, 2'b00},  // R3 new destination
    {16'h0000, 3'd0, 8'h42, 2'b00},  // R2 back to comparand
    {16'h0700, 3'd0, 8'h42, 2'b00},  // R6 function 111
    {16'h0600, 3'd0, 8'h42, 2'b00}   // R6 function 110
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmdWrite(input logic [15:0] w);
    @(negedge clk);
    cmdWr = 1'b1;
    wrData = w;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic cmdRead(output logic [31:0] d, output logic en, output logic [2:0] sel);
    @(negedge clk);
    cmdRd = 1'b1;
    #1;
    d = dqOut;
    en = regRdEn;
    sel = regRdSel;
    @(negedge clk);
    cmdRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        en;
    logic [2:0]  sel;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 src", {29'd0, srcSel}, 32'd0);
    chk("R1 dst", {24'd0, dstMask, dstSel, dstValid}, 32'd0);
    chk("R1 strobes", {29'd0, movStb, vbcStb, regWrEn}, 32'd0);
    chk("R12 idle read", dqOut, 32'hDEAD_BEEF);

    for (int i = 0; i < 12; i++) begin
      cmdWrite(VEC[i][28:13]);
      chk("R2 vec src", {29'd0, srcSel}, {29'd0, VEC[i][12:10]});
      chk("R3 vec dst", {24'd0, dstMask, dstSel, dstValid}, {24'd0, VEC[i][9:2]});
      chk("R6 vec pulses", {30'd0, movStb, vbcStb}, {30'd0, VEC[i][1:0]});
    end

    // R4 move fields
    cmdWrite(16'h0BD6);
    chk("R4 move args", {22'd0, movStb, argFlag, argMask, argDst, argLow},
        {22'd0, 1'b1, 1'b1, 2'd3, 3'd2, 3'd6});
    @(negedge clk);
    chk("R4 single pulse", {31'd0, movStb}, 32'd0);

    // R5 validity control fields
    cmdWrite(16'h0C2B);
    chk("R5 vbc args", {22'd0, vbcStb, argFlag, argMask, argDst, argLow},
        {22'd0, 1'b1, 1'b1, 2'd0, 3'd5, 3'd3});

    // R8 read override of next-free (regRdData path)
    cmdWrite(16'h0218);
    cmdRead(d, en, sel);
    chk("R8 override read data", d, 32'hDEAD_1234);
    chk("R8 read enable/sel", {28'd0, en, sel}, {28'd0, 1'b1, 3'd3});
    cmdRead(d, en, sel);
    chk("R12 status after override", d, 32'hDEAD_BEEF);
    chk("R7 override consumed", {31'd0, en}, 32'd0);

    // R11 source view with device id
    cmdWrite(16'h0005);
    cmdWrite(16'h0228);
    cmdRead(d, en, sel);
    chk("R11 source view", d, 32'hDEAD_A5C5);

    // R11 destination view
    cmdWrite(16'h0230);
    cmdRead(d, en, sel);
    chk("R11 destination view", d, 32'hDEAD_0042);

    // R11 status via override
    statusIn = 32'h5A5A_C3C3;
    cmdWrite(16'h0220);
    cmdRead(d, en, sel);
    chk("R11 status view", d, 32'h5A5A_C3C3);
    statusIn = 32'hDEAD_BEEF;

    // R9 write override to a writable register
    cmdWrite(16'h0A08);
    cmdWrite(16'h0003);
    chk("R9 write pulse", {12'd0, regWrEn, regWrSel, regWrData},
        {12'd0, 1'b1, 3'd1, 16'h0003});
    chk("R9 not decoded", {29'd0, srcSel}, 32'd5);
    @(negedge clk);
    chk("R9 pulse ends", {31'd0, regWrEn}, 32'd0);
    cmdWrite(16'h0003);
    chk("R12 decoder restored", {29'd0, srcSel}, 32'd3);

    // R10 write override to read-only source view
    cmdWrite(16'h0A28);
    cmdWrite(16'h0001);
    chk("R10 no write", {31'd0, regWrEn}, 32'd0);
    chk("R10 not decoded", {29'd0, srcSel}, 32'd3);
    cmdRead(d, en, sel);
    chk("R10 consumed", d, 32'hDEAD_BEEF);

    // R8 write during read-mode override is decoded
    cmdWrite(16'h0218);
    cmdWrite(16'h0006);
    chk("R8 write decoded", {29'd0, srcSel}, 32'd6);
    cmdRead(d, en, sel);
    chk("R7 consumed by write", {31'd0, en}, 32'd0);

    // R9 read during write-mode override returns status
    cmdWrite(16'h0A08);
    cmdRead(d, en, sel);
    chk("R9 read gives status", d, 32'hDEAD_BEEF);
    chk("R9 no read enable", {31'd0, en}, 32'd0);
    cmdWrite(16'h0002);
    chk("R9 then decoded", {29'd0, srcSel}, 32'd2);
    chk("R9 no stale write", {31'd0, regWrEn}, 32'd0);

    // R13 read and write in the same override cycle
    cmdWrite(16'h0218);
    @(negedge clk);
    cmdRd = 1'b1;
    cmdWr = 1'b1;
    wrData = 16'h0004;
    #1;
    chk("R13 read served", dqOut, 32'hDEAD_1234);
    @(negedge clk);
    cmdRd = 1'b0;
    cmdWr = 1'b0;
    chk("R13 write decoded", {29'd0, srcSel}, 32'd4);
    cmdRead(d, en, sel);
    chk("R13 single consume", d, 32'hDEAD_BEEF);

    // R1 reset clears armed override and selects
    cmdWrite(16'h0218);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset src", {24'd0, srcSel, dstMask, dstSel}, 32'd0);
    cmdRead(d, en, sel);
    chk("R1 reset disarms", d, 32'hDEAD_BEEF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule